// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block keeps the running CRC-8 packet error code of one SMBus message. The bus controller around it pulses a clear strobe when it sees the first START of a message. It then hands over each byte that crosses the wire, one at a time, with a valid strobe. These bytes are the address byte, the command byte, the second address byte after a repeated START, and every data byte. The engine folds each byte into its code register in a single cycle. The controller never passes on line conditions or acknowledge bits, so they never reach the code.

A transmitter reads `pec_o` after the last payload byte and sends it as the code byte. A receiver also feeds the received code byte through the valid strobe. The register then falls to zero exactly when the message arrived intact, and `match_o` reports that condition from the cycle after the byte.

Top module: `smbus_pec_engine`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `pec_o` is 0x00 and `match_o` is 0. Asserting reset in the middle of a message returns both outputs to these values.
- R2: The code uses the generator x^8+x^2+x+1 (0x07 with the top term dropped). It starts from 0x00, applies no final inversion, and takes the bits of each byte most significant bit first. The code equals the remainder of the message, with eight zero bits appended, divided by the generator. A single byte 0x01 gives 0x07, and the ASCII string "123456789" gives 0xF4.
- R3: A cycle with `clear_i` high sets `pec_o` to 0x00 and `match_o` to 0 from the next cycle on.
- R4: In a cycle with neither `clear_i` nor `valid_i` high, `pec_o` and `match_o` keep their values.
- R5: When `clear_i` and `valid_i` are both high in the same cycle, the clear wins and the byte on `data_i` is discarded.
- R6: A byte presented with `valid_i` is folded in at the next rising edge, so bytes may be presented on consecutive cycles. The code spans every byte since the last clear, including a second address byte after a repeated START. Nothing other than a clear restarts it.
- R7: After a byte is accepted, `match_o` is 1 exactly when the resulting code is 0x00. Feeding the correct code byte after a message therefore raises `match_o`, and a wrong code byte leaves it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Restart the code at the first START of a message |
| valid_i | input | 1 | `data_i` holds a transferred byte this cycle |
| data_i | input | 8 | Byte as it appears on the wire |
| pec_o | output | 8 | Running packet error code |
| match_o | output | 1 | Last accepted byte left the code at zero |

## Verification
The code register is compared against a long-division model that recomputes the augmented remainder over the whole message after every byte. This model is exercised with a write-word transaction, a read-word transaction that contains a repeated-START address byte, and a standard check string. Together these cases distinguish a wrong polynomial, a reversed bit order, a nonzero start value and an accumulator that restarts on the second address byte. Further tests feed a correct code byte and then a wrong code byte, to separate a true zero result from a flag that stays stuck. A clear that coincides with a valid byte, idle cycles, bytes on consecutive cycles and a reset in the middle of a message cover the control priorities.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned PEC_BYTE_W = 8;
  localparam int unsigned PEC_CODE_W = 8;
  localparam logic [PEC_CODE_W-1:0] PEC_POLY = 8'h07;
endpackage

// File: rtl/pec_byte_step.sv
module pec_byte_step #(
  parameter int unsigned CODE_W = pec_pkg::PEC_CODE_W,
  parameter int unsigned BYTE_W = pec_pkg::PEC_BYTE_W,
  parameter logic [CODE_W-1:0] POLY = pec_pkg::PEC_POLY
) (
  input  logic [CODE_W-1:0] crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CODE_W-1:0] crc_o
);
  // one shift-and-xor stage per input bit, most significant bit first
  logic [CODE_W-1:0] chain [0:BYTE_W];

  assign chain[0] = crc_i;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CODE_W-1] ^ data_i[BYTE_W-1-i];
    assign chain[i+1] = {chain[i][CODE_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[BYTE_W];
endmodule

// File: rtl/pec_zero_detect.sv
module pec_zero_detect #(
  parameter int unsigned CODE_W = pec_pkg::PEC_CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              zero_o
);
  assign zero_o = ~|code_i;
endmodule

// File: rtl/pec_state_reg.sv
module pec_state_reg #(
  parameter int unsigned CODE_W = pec_pkg::PEC_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] step_code_i,
  input  logic              step_zero_i,
  output logic [CODE_W-1:0] code_q_o,
  output logic              match_q_o
);
  logic [CODE_W-1:0] code_d, code_q;
  logic              match_d, match_q;
  logic              load_en;

  assign load_en = clear_i | valid_i;

  always_comb begin
    code_d  = code_q;
    match_d = match_q;
    if (clear_i) begin
      code_d  = '0;
      match_d = 1'b0;
    end else if (valid_i) begin
      code_d  = step_code_i;
      match_d = step_zero_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      match_q <= 1'b0;
    end else if (load_en) begin
      code_q  <= code_d;
      match_q <= match_d;
    end
  end

  assign code_q_o  = code_q;
  assign match_q_o = match_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (code_q == '0) && !match_q); // R3

  AST_CLEAR_BEATS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && valid_i) |=> (code_q == '0)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> $stable(code_q) && $stable(match_q)); // R4

  AST_MATCH_MEANS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (code_q == '0)); // R7
endmodule

// File: rtl/smbus_pec_engine.sv
module smbus_pec_engine #(
  parameter int unsigned CODE_W = pec_pkg::PEC_CODE_W,
  parameter int unsigned BYTE_W = pec_pkg::PEC_BYTE_W,
  parameter logic [CODE_W-1:0] POLY = pec_pkg::PEC_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CODE_W-1:0] pec_o,
  output logic              match_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] step_code;
  logic              step_zero;

  pec_byte_step #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .POLY(POLY)) step_i (
    .crc_i  (code_q),
    .data_i (data_i),
    .crc_o  (step_code)
  );

  pec_zero_detect #(.CODE_W(CODE_W)) zero_i (
    .code_i (step_code),
    .zero_o (step_zero)
  );

  pec_state_reg #(.CODE_W(CODE_W)) state_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .valid_i     (valid_i),
    .step_code_i (step_code),
    .step_zero_i (step_zero),
    .code_q_o    (code_q),
    .match_q_o   (match_o)
  );

  assign pec_o = code_q;

  AST_ZERO_BYTE_KEEPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && (pec_o == '0) && (data_i == '0)) |=> (pec_o == '0)); // R2

  AST_BYTE_CHANGES_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clear_i && (data_i != '0)) |=> !$stable(pec_o) || !$stable(match_o) || match_o == 1'b0); // R6
endmodule

// File: tb/smbus_pec_engine_tb_top.sv
`timescale 1ns/1ps
module smbus_pec_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clear;
  logic       valid;
  logic [7:0] data;
  logic [7:0] pec;
  logic       match;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smbus_pec_engine dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .clear_i (clear),
    .valid_i (valid),
    .data_i  (data),
    .pec_o   (pec),
    .match_o (match)
  );

  // bit 8 set: clear strobe; otherwise a byte
  localparam logic [8:0] VEC [20] = '{
    9'h100, 9'h0B4, 9'h007, 9'h0B5, 9'h03A, 9'h019,
    9'h100, 9'h0B4, 9'h023, 9'h0D2, 9'h004,
    9'h100, 9'h0FF, 9'h080, 9'h001, 9'h000,
    9'h100, 9'h05A, 9'h0A5, 9'h0C3
  };

  logic [7:0] msg [0:63];
  int         msg_len = 0;

  // long division of the message with eight zero bits appended
  function automatic logic [7:0] ref_pec(input int len);
    logic [7:0] r = 8'h00;
    logic       top;
    for (int k = 0; k < len + 1; k++) begin
      for (int b = 7; b >= 0; b--) begin
        logic bit_in = (k < len) ? msg[k][b] : 1'b0;
        top = r[7];
        r = {r[6:0], bit_in};
        if (top) r = r ^ 8'h07;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act_c, input logic [7:0] exp_c,
                       input logic act_m, input logic exp_m);
    checks++;
    if (act_c !== exp_c || act_m !== exp_m) begin
      errors++;
      $display("FAIL %s pec=%02h match=%0b expected pec=%02h match=%0b", req, act_c, act_m, exp_c, exp_m);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1; valid = 1'b0;
    @(negedge clk); clear = 1'b0;
    msg_len = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); valid = 1'b1; data = b;
    @(negedge clk); valid = 1'b0;
    msg[msg_len] = b; msg_len++;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] good;
    rst_n = 1'b0; clear = 1'b0; valid = 1'b0; data = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 during reset", pec, 8'h00, match, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pec, 8'h00, match, 1'b0);

    // table walk against the division model (R2, R3, R6, R7)
    for (int k = 0; k < 20; k++) begin
      if (VEC[k][8]) begin
        do_clear();
        check("R3 clear", pec, 8'h00, match, 1'b0);
      end else begin
        send_byte(VEC[k][7:0]);
        good = ref_pec(msg_len);
        check("R6 running code", pec, good, match, good == 8'h00);
      end
    end

    // known single byte and check string (R2)
    do_clear();
    send_byte(8'h01);
    check("R2 byte 01", pec, 8'h07, match, 1'b0);
    do_clear();
    foreach (VEC[k]) ; // no-op to keep loop variable use uniform
    for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k));
    check("R2 check string", pec, 8'hF4, match, 1'b0);

    // read transaction with repeated START, then correct code byte (R6, R7)
    do_clear();
    send_byte(8'hB4); send_byte(8'h07); send_byte(8'hB5);
    send_byte(8'hD2); send_byte(8'h3A);
    good = ref_pec(msg_len);
    check("R6 repeated start read", pec, good, match, good == 8'h00);
    send_byte(good);
    check("R7 correct code matches", pec, 8'h00, match, 1'b1);
    // idle keeps state (R4)
    repeat (4) @(negedge clk);
    check("R4 idle holds match", pec, 8'h00, match, 1'b1);

    // wrong code byte (R7)
    do_clear();
    send_byte(8'hB4); send_byte(8'h07); send_byte(8'hB5);
    send_byte(8'hD2); send_byte(8'h3A);
    good = ref_pec(msg_len);
    send_byte(good ^ 8'h01);
    check("R7 wrong code", pec, 8'h07, match, 1'b0);

    // clear and byte together (R5)
    do_clear();
    send_byte(8'h5A);
    @(negedge clk); clear = 1'b1; valid = 1'b1; data = 8'h33;
    @(negedge clk); clear = 1'b0; valid = 1'b0;
    check("R5 clear wins", pec, 8'h00, match, 1'b0);
    msg_len = 0;
    repeat (3) @(negedge clk);
    check("R4 idle after clear", pec, 8'h00, match, 1'b0);

    // back-to-back bytes (R6)
    do_clear();
    @(negedge clk); valid = 1'b1; data = 8'hA5;
    @(negedge clk); data = 8'h3C;
    @(negedge clk); data = 8'hC3;
    @(negedge clk); valid = 1'b0;
    msg[0] = 8'hA5; msg[1] = 8'h3C; msg[2] = 8'hC3; msg_len = 3;
    good = ref_pec(3);
    check("R6 consecutive bytes", pec, good, match, good == 8'h00);

    // reset mid message (R1)
    send_byte(8'h77);
    #1 rst_n = 1'b0;
    #1 check("R1 mid-message reset", pec, 8'h00, match, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after second release", pec, 8'h00, match, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule